// File: doc/BRIEF.md
# Radio Receive Pipe Allocator

This block manages the six receive pipes of a 2.4 GHz transceiver that is configured through byte-wide SPI register accesses. It keeps a local table with one node byte and one enable flag for each pipe. An add-node request claims the lowest pipe that is not enabled. The block then programs that pipe's receive address on the radio and sets the pipe's bit in the radio's pipe-enable register. It does this with a read-modify-write, so any bit it does not own keeps its value.

Besides add-node, the block programs an address on a chosen pipe, enables or disables a single pipe, clears the whole table, and answers two lookups from its local table: pipe to node byte, and node byte to pipe. Each SPI byte goes to an external byte engine through a valid/done handshake. A separate flag marks the last byte of each chip-select transaction. Only one request is handled at a time.

Top module: `rx_pipe_alloc`

## Requirements
- R1: After reset `busy`, `respValid` and `spiValid` are low. Every pipe is free and holds node byte 0x00.
- R2: Add-node (reqOp=0) picks the lowest-numbered pipe whose enable flag is clear. The response has respErr=0, respData set to the pipe number, and the pipe records the node byte and becomes enabled.
- R3: The address write is one transaction. Its command byte is 0x20 OR (0x0A + pipe). For pipes 0 and 1 the command is followed by netBase[7:0], netBase[15:8], netBase[23:16], netBase[31:24] and then the node byte. For pipes 2 to 5 only the node byte follows.
- R4: Enabling a pipe (add-node, or reqOp=2) sends the read transaction {0x02, 0x00} and captures the byte returned with the second byte. It then sends the write transaction {0x22, captured OR (1<<pipe)}. Disabling (reqOp=3) writes the captured value AND NOT (1<<pipe). All other bits of that register are written back unchanged.
- R5: Add-node with all six pipes enabled responds with respErr=1 and respData=0xFF, and produces no SPI traffic.
- R6: Set-address (reqOp=1) with reqPipe above 5 responds with respErr=1 and respData=0x00, with no SPI traffic. With a valid pipe it performs the R3 transaction, stores the node byte and leaves the enable flag unchanged. Enable and disable with reqPipe above 5 are rejected the same way.
- R7: Forward lookup (reqOp=4) answers in the cycle after acceptance, with no SPI traffic. It returns the stored node byte with respErr=0, or 0x00 with respErr=1 when reqPipe is above 5.
- R8: Reverse lookup (reqOp=5) answers in the cycle after acceptance. It returns the lowest pipe whose stored node byte equals reqNode, or 0xFF with respErr=1 when no pipe matches.
- R9: Clear (reqOp=6) sends the single transaction {0x22, 0x00}. Afterwards every node byte is 0x00 and every enable flag is clear, and the response is respErr=0, respData=0x00.
- R10: `busy` is high from the cycle after an SPI-using request is accepted until the response appears, and requests presented while busy are ignored. `respValid` pulses for one cycle, the cycle after the final `spiDone`.
- R11: `spiValid`, `spiByte` and `spiLast` stay stable until `spiDone`. `spiLast` is high only on the final byte of each transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqOp | input | 3 | 0 add, 1 set-address, 2 enable, 3 disable, 4 forward lookup, 5 reverse lookup, 6 clear |
| reqPipe | input | 3 | Pipe number for set-address, enable, disable and forward lookup |
| reqNode | input | 8 | Node byte for add, set-address and reverse lookup |
| netBase | input | 32 | Shared network base, byte k in bits 8k+7:8k |
| busy | output | 1 | A request is being carried out over SPI |
| respValid | output | 1 | One-cycle response strobe |
| respErr | output | 1 | Request failed or lookup missed |
| respData | output | 8 | Pipe number, node byte, or 0xFF/0x00 on failure |
| spiValid | output | 1 | A byte is offered to the SPI engine |
| spiByte | output | 8 | Byte to shift out |
| spiLast | output | 1 | Byte ends the chip-select transaction |
| spiDone | input | 1 | Engine finished the offered byte |
| spiRx | input | 8 | Byte shifted in, valid with spiDone |

## Verification
The bench builds the block with its default parameters: six pipes, two of them taking the full five-byte address, and a four-byte base. Its SPI engine model answers each byte after two idle cycles. With six pipes, the bench can fill the table completely to reach the full case, and can open a hole with a disable so the next add is steered into it. Because the pipe field is three bits wide, the numbers 6 and 7 can be driven to exercise the rejection paths. The radio model starts with its pipe-enable register at 0xC0, so every read-modify-write has to carry the two bits the block does not own.

// File: rtl/pipe_alloc_pkg.sv
package pipe_alloc_pkg;

  localparam logic [7:0] CMD_WR        = 8'h20;
  localparam logic [7:0] CMD_RD        = 8'h00;
  localparam logic [7:0] REG_PIPE_EN   = 8'h02;
  localparam logic [7:0] REG_ADDR_BASE = 8'h0A;

  typedef enum logic [2:0] {
    OP_ADD     = 3'd0,
    OP_SETADDR = 3'd1,
    OP_ENABLE  = 3'd2,
    OP_DISABLE = 3'd3,
    OP_FWD     = 3'd4,
    OP_REV     = 3'd5,
    OP_CLEAR   = 3'd6,
    OP_RSVD    = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_RD   = 2'd1,
    PH_WR   = 2'd2
  } phase_e;

  typedef struct packed {
    logic   latch;
    logic   idxClr;
    logic   idxInc;
    logic   capRx;
    phase_e phase;
    logic   tblSetNode;
    logic   tblSetEn;
    logic   tblClrEn;
    logic   tblClear;
    logic   respImm;
    logic   respEnd;
  } ctl_s;

endpackage

// File: rtl/pipe_alloc_dp.sv
module pipe_alloc_dp
  import pipe_alloc_pkg::*;
#(
  parameter int NUM_PIPES  = 6,
  parameter int WIDE_PIPES = 2,
  parameter int BASE_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctl_s                    ctl,
  input  logic [2:0]              reqOp,
  input  logic [2:0]              reqPipe,
  input  logic [7:0]              reqNode,
  input  logic [8*BASE_BYTES-1:0] netBase,
  input  logic [7:0]              spiRx,
  output logic [7:0]              spiByte,
  output logic                    spiLastByte,
  output logic                    noFree,
  output logic                    pipeBad,
  output opcode_e                 opKind,
  output logic                    respValid,
  output logic                    respErr,
  output logic [7:0]              respData
);

  localparam int ADDR_LEN = BASE_BYTES + 1;
  localparam int IDX_W    = $clog2(ADDR_LEN + 1);

  logic [7:0]           nodeTab [NUM_PIPES];
  logic [NUM_PIPES-1:0] enTab;
  logic [2:0]           opPipe;
  logic [7:0]           opNode;
  logic [IDX_W-1:0]     idx;
  logic [7:0]           rxCap;

  logic [2:0] freePipe;
  logic [2:0] revPipe;
  logic       revHit;
  logic [7:0] fwdNode;
  logic [7:0] pipeMask;
  logic [7:0] wrVal;
  logic       widePipe;
  logic       immErr;
  logic [7:0] immData;

  // lowest free pipe
  always_comb begin
    noFree   = 1'b1;
    freePipe = '0;
    for (int i = NUM_PIPES - 1; i >= 0; i--) begin
      if (!enTab[i]) begin
        noFree   = 1'b0;
        freePipe = 3'(i);
      end
    end
  end

  // lowest pipe holding the requested node byte
  always_comb begin
    revHit  = 1'b0;
    revPipe = '0;
    for (int i = NUM_PIPES - 1; i >= 0; i--) begin
      if (nodeTab[i] == reqNode) begin
        revHit  = 1'b1;
        revPipe = 3'(i);
      end
    end
  end

  always_comb begin
    fwdNode = '0;
    for (int i = 0; i < NUM_PIPES; i++) begin
      if (int'(reqPipe) == i) fwdNode = nodeTab[i];
    end
  end

  assign pipeBad  = int'(reqPipe) >= NUM_PIPES;
  assign widePipe = int'(opPipe) < WIDE_PIPES;
  assign pipeMask = 8'(1) << opPipe;

  always_comb begin
    case (opKind)
      OP_CLEAR:   wrVal = 8'h00;
      OP_DISABLE: wrVal = rxCap & ~pipeMask;
      default:    wrVal = rxCap | pipeMask;
    endcase
  end

  // byte offered to the SPI engine for the current phase and index
  always_comb begin
    spiByte     = 8'h00;
    spiLastByte = 1'b0;
    case (ctl.phase)
      PH_ADDR: begin
        if (idx == '0) begin
          spiByte = CMD_WR | (REG_ADDR_BASE + {5'b0, opPipe});
        end else begin
          spiByte = opNode;
          if (widePipe) begin
            for (int b = 0; b < BASE_BYTES; b++) begin
              if (int'(idx) == b + 1) spiByte = netBase[8*b +: 8];
            end
          end
        end
        spiLastByte = widePipe ? (idx == IDX_W'(ADDR_LEN)) : (idx == IDX_W'(1));
      end
      PH_RD: begin
        spiByte     = (idx == '0) ? (CMD_RD | REG_PIPE_EN) : 8'h00;
        spiLastByte = (idx == IDX_W'(1));
      end
      default: begin
        spiByte     = (idx == '0) ? (CMD_WR | REG_PIPE_EN) : wrVal;
        spiLastByte = (idx == IDX_W'(1));
      end
    endcase
  end

  // responses that need no SPI traffic
  always_comb begin
    immErr  = 1'b1;
    immData = 8'h00;
    case (opcode_e'(reqOp))
      OP_ADD: immData = 8'hFF;
      OP_FWD: begin
        immErr  = pipeBad;
        immData = pipeBad ? 8'h00 : fwdNode;
      end
      OP_REV: begin
        immErr  = !revHit;
        immData = revHit ? {5'b0, revPipe} : 8'hFF;
      end
      default: begin
        immErr  = 1'b1;
        immData = 8'h00;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opPipe    <= '0;
      opNode    <= '0;
      opKind    <= OP_ADD;
      idx       <= '0;
      rxCap     <= '0;
      enTab     <= '0;
      respValid <= 1'b0;
      respErr   <= 1'b0;
      respData  <= '0;
      for (int i = 0; i < NUM_PIPES; i++) nodeTab[i] <= '0;
    end else begin
      if (ctl.latch) begin
        opPipe <= (opcode_e'(reqOp) == OP_ADD) ? freePipe : reqPipe;
        opNode <= reqNode;
        opKind <= opcode_e'(reqOp);
      end
      if (ctl.idxClr)      idx <= '0;
      else if (ctl.idxInc) idx <= idx + IDX_W'(1);
      if (ctl.capRx) rxCap <= spiRx;

      for (int i = 0; i < NUM_PIPES; i++) begin
        if (ctl.tblClear) begin
          nodeTab[i] <= '0;
          enTab[i]   <= 1'b0;
        end else if (opPipe == 3'(i)) begin
          if (ctl.tblSetNode) nodeTab[i] <= opNode;
          if (ctl.tblSetEn)   enTab[i]   <= 1'b1;
          if (ctl.tblClrEn)   enTab[i]   <= 1'b0;
        end
      end

      respValid <= ctl.respImm | ctl.respEnd;
      if (ctl.respImm) begin
        respErr  <= immErr;
        respData <= immData;
      end else if (ctl.respEnd) begin
        respErr  <= 1'b0;
        respData <= (opKind == OP_CLEAR) ? 8'h00 : {5'b0, opPipe};
      end
    end
  end

  logic [7:0] enVec;
  logic [7:0] lowMask;
  assign enVec   = 8'(enTab);
  assign lowMask = pipeMask - 8'd1;

  // R2: an add only claims a pipe when every lower pipe is taken and the claimed one is free
  a_r2_lowest_free: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.tblSetEn && opKind == OP_ADD) |-> ((enVec & lowMask) == lowMask) && ((enVec & pipeMask) == 8'h00));

  // R9: a clear leaves no pipe enabled
  a_r9_clear_empty: assert property (@(posedge clk) disable iff (!rstN)
    ctl.tblClear |=> (enVec == 8'h00));

endmodule

// File: rtl/pipe_alloc_ctl.sv
module pipe_alloc_ctl
  import pipe_alloc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqOp,
  input  logic       noFree,
  input  logic       pipeBad,
  input  opcode_e    opKind,
  input  logic       spiDone,
  input  logic       spiLastByte,
  output ctl_s       ctl,
  output logic       busy,
  output logic       spiValid
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } state_e;

  state_e state, stateNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          case (opcode_e'(reqOp))
            OP_ADD: begin
              if (noFree) ctl.respImm = 1'b1;
              else begin
                ctl.latch  = 1'b1;
                ctl.idxClr = 1'b1;
                stateNext  = ST_ADDR;
              end
            end
            OP_SETADDR: begin
              if (pipeBad) ctl.respImm = 1'b1;
              else begin
                ctl.latch  = 1'b1;
                ctl.idxClr = 1'b1;
                stateNext  = ST_ADDR;
              end
            end
            OP_ENABLE, OP_DISABLE: begin
              if (pipeBad) ctl.respImm = 1'b1;
              else begin
                ctl.latch  = 1'b1;
                ctl.idxClr = 1'b1;
                stateNext  = ST_RD;
              end
            end
            OP_CLEAR: begin
              ctl.latch  = 1'b1;
              ctl.idxClr = 1'b1;
              stateNext  = ST_WR;
            end
            default: ctl.respImm = 1'b1;
          endcase
        end
      end
      ST_ADDR: begin
        ctl.phase = PH_ADDR;
        if (spiDone) begin
          if (spiLastByte) begin
            if (opKind == OP_SETADDR) begin
              ctl.tblSetNode = 1'b1;
              ctl.respEnd    = 1'b1;
              stateNext      = ST_IDLE;
            end else begin
              ctl.idxClr = 1'b1;
              stateNext  = ST_RD;
            end
          end else begin
            ctl.idxInc = 1'b1;
          end
        end
      end
      ST_RD: begin
        ctl.phase = PH_RD;
        if (spiDone) begin
          if (spiLastByte) begin
            ctl.capRx  = 1'b1;
            ctl.idxClr = 1'b1;
            stateNext  = ST_WR;
          end else begin
            ctl.idxInc = 1'b1;
          end
        end
      end
      default: begin
        ctl.phase = PH_WR;
        if (spiDone) begin
          if (spiLastByte) begin
            case (opKind)
              OP_ADD: begin
                ctl.tblSetNode = 1'b1;
                ctl.tblSetEn   = 1'b1;
              end
              OP_ENABLE:  ctl.tblSetEn = 1'b1;
              OP_DISABLE: ctl.tblClrEn = 1'b1;
              default:    ctl.tblClear = 1'b1;
            endcase
            ctl.respEnd = 1'b1;
            stateNext   = ST_IDLE;
          end else begin
            ctl.idxInc = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy     = (state != ST_IDLE);
  assign spiValid = busy;

  // R5: an add with no free pipe starts no SPI work
  a_r5_full_no_spi: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqValid && reqOp == 3'd0 && noFree) |=> !busy);

  // R6: an out-of-range pipe for an address write starts no SPI work
  a_r6_bad_pipe_no_spi: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqValid && reqOp == 3'd1 && pipeBad) |=> !busy);

endmodule

// File: rtl/rx_pipe_alloc.sv
module rx_pipe_alloc
  import pipe_alloc_pkg::*;
#(
  parameter int NUM_PIPES  = 6,
  parameter int WIDE_PIPES = 2,
  parameter int BASE_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [2:0]              reqOp,
  input  logic [2:0]              reqPipe,
  input  logic [7:0]              reqNode,
  input  logic [8*BASE_BYTES-1:0] netBase,
  output logic                    busy,
  output logic                    respValid,
  output logic                    respErr,
  output logic [7:0]              respData,
  output logic                    spiValid,
  output logic [7:0]              spiByte,
  output logic                    spiLast,
  input  logic                    spiDone,
  input  logic [7:0]              spiRx
);

  ctl_s    ctl;
  opcode_e opKind;
  logic    noFree;
  logic    pipeBad;
  logic    spiLastByte;

  pipe_alloc_ctl u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqOp       (reqOp),
    .noFree      (noFree),
    .pipeBad     (pipeBad),
    .opKind      (opKind),
    .spiDone     (spiDone),
    .spiLastByte (spiLastByte),
    .ctl         (ctl),
    .busy        (busy),
    .spiValid    (spiValid)
  );

  pipe_alloc_dp #(
    .NUM_PIPES  (NUM_PIPES),
    .WIDE_PIPES (WIDE_PIPES),
    .BASE_BYTES (BASE_BYTES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqOp       (reqOp),
    .reqPipe     (reqPipe),
    .reqNode     (reqNode),
    .netBase     (netBase),
    .spiRx       (spiRx),
    .spiByte     (spiByte),
    .spiLastByte (spiLastByte),
    .noFree      (noFree),
    .pipeBad     (pipeBad),
    .opKind      (opKind),
    .respValid   (respValid),
    .respErr     (respErr),
    .respData    (respData)
  );

  assign spiLast = spiValid & spiLastByte;

  // R11: an offered byte holds until the engine reports it done
  a_r11_byte_hold: assert property (@(posedge clk) disable iff (!rstN)
    (spiValid && !spiDone) |=> spiValid && $stable(spiByte) && $stable(spiLast));

  // R10: a response is only shown once SPI work has finished
  a_r10_resp_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !busy);

endmodule

// File: tb/test_rx_pipe_alloc.sv
module test_rx_pipe_alloc;

  localparam int LAT = 2;
  localparam logic [31:0] BASE = 32'hA1B2C3D4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqOp = '0;
  logic [2:0] reqPipe = '0;
  logic [7:0] reqNode = '0;
  logic       busy, respValid, respErr, spiValid, spiLast;
  logic [7:0] respData, spiByte;
  logic       spiDone = 1'b0;
  logic [7:0] spiRx = '0;

  always #5 clk = ~clk;

  rx_pipe_alloc i_rx_pipe_alloc (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqPipe(reqPipe),
    .reqNode(reqNode), .netBase(BASE), .busy(busy), .respValid(respValid),
    .respErr(respErr), .respData(respData), .spiValid(spiValid), .spiByte(spiByte),
    .spiLast(spiLast), .spiDone(spiDone), .spiRx(spiRx)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit quiet = 1;

  // external radio model and SPI log
  logic [7:0] radioEn = 8'hC0;
  logic [7:0] logB[$];
  bit         logL[$];
  logic [7:0] expB[$];
  bit         expL[$];

  // behavioural reference table
  int expNode[6];
  bit expEn[6];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // SPI byte engine model
  initial begin
    int wcnt = LAT;
    int txIdx = 0;
    logic [7:0] txCmd = 8'h00;
    forever begin
      @(negedge clk);
      if (spiDone) spiDone = 1'b0;
      else if (spiValid) begin
        if (wcnt > 0) wcnt--;
        else begin
          wcnt = LAT;
          logB.push_back(spiByte);
          logL.push_back(spiLast);
          if (txIdx == 0) begin
            txCmd = spiByte;
            spiRx = 8'h0E;
          end else if (txCmd[7:5] == 3'b000) begin
            spiRx = (txCmd[4:0] == 5'h02) ? radioEn : 8'h00;
          end else begin
            spiRx = 8'h00;
            if (txCmd[4:0] == 5'h02) radioEn = spiByte;
          end
          txIdx = spiLast ? 0 : txIdx + 1;
          spiDone = 1'b1;
        end
      end
    end
  end

  // per-cycle monitor: nothing moves between requests
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (quiet && rstN) begin
        chk(!spiValid && !respValid && !busy, "R10 idle outputs", {spiValid, respValid, busy}, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic pushTx(input logic [7:0] b, input bit last);
    expB.push_back(b);
    expL.push_back(last);
  endtask

  task automatic pushAddr(input int p, input logic [7:0] n);
    pushTx(8'h20 | (8'h0A + 8'(p)), 0);
    if (p < 2) begin
      for (int k = 0; k < 4; k++) pushTx(BASE[8*k +: 8], 0);
    end
    pushTx(n, 1);
  endtask

  task automatic pushRmw(input logic [7:0] v);
    pushTx(8'h02, 0);
    pushTx(8'h00, 1);
    pushTx(8'h22, 0);
    pushTx(v, 1);
  endtask

  task automatic cmpSpi(input string req);
    chk(logB.size() == expB.size(), {req, " SPI byte count"}, logB.size(), expB.size());
    if (logB.size() == expB.size()) begin
      for (int k = 0; k < expB.size(); k++) begin
        chk(logB[k] == expB[k], {req, " SPI byte"}, logB[k], expB[k]);
        chk(logL[k] == expL[k], "R11 last flag", logL[k], expL[k]);
      end
    end
    expB.delete();
    expL.delete();
  endtask

  task automatic doOp(input logic [2:0] op, input int p, input logic [7:0] n,
                      input bit viaSpi, output logic e, output logic [7:0] d);
    int lat = 0;
    @(negedge clk);
    quiet = 0;
    logB.delete();
    logL.delete();
    reqValid = 1'b1;
    reqOp = op;
    reqPipe = p[2:0];
    reqNode = n;
    @(negedge clk);
    reqValid = 1'b0;
    if (viaSpi) chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    while (!respValid && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    chk(respValid == 1'b1, "R10 response seen", respValid, 1);
    if (!viaSpi) chk(lat == 0, "R7 immediate answer", lat, 0);
    else chk(busy == 1'b0, "R10 busy released", busy, 0);
    e = respErr;
    d = respData;
    @(negedge clk);
    chk(respValid == 1'b0, "R10 single pulse", respValid, 0);
    quiet = 1;
  endtask

  task automatic tAdd(input logic [7:0] n);
    int p = -1;
    logic e;
    logic [7:0] d;
    for (int i = 5; i >= 0; i--) if (!expEn[i]) p = i;
    if (p < 0) begin
      doOp(3'd0, 0, n, 0, e, d);
      chk(e == 1'b1 && d == 8'hFF, "R5 add when full", {e, d}, {1'b1, 8'hFF});
      cmpSpi("R5");
    end else begin
      pushAddr(p, n);
      pushRmw(radioEn | (8'd1 << p));
      doOp(3'd0, 0, n, 1, e, d);
      chk(e == 1'b0 && d == 8'(p), "R2 add picks lowest free", {e, d}, p);
      cmpSpi(p < 2 ? "R3 wide/R4" : "R3 narrow/R4");
      expNode[p] = n;
      expEn[p] = 1;
    end
  endtask

  task automatic tSetAddr(input int p, input logic [7:0] n);
    logic e;
    logic [7:0] d;
    if (p > 5) begin
      doOp(3'd1, p, n, 0, e, d);
      chk(e == 1'b1 && d == 8'h00, "R6 bad pipe rejected", {e, d}, {1'b1, 8'h00});
      cmpSpi("R6");
    end else begin
      pushAddr(p, n);
      doOp(3'd1, p, n, 1, e, d);
      chk(e == 1'b0 && d == 8'(p), "R6 set-address", {e, d}, p);
      cmpSpi("R6 R3");
      expNode[p] = n;
    end
  endtask

  task automatic tEnDis(input int p, input bit en);
    logic e;
    logic [7:0] d;
    if (p > 5) begin
      doOp(en ? 3'd2 : 3'd3, p, 8'h00, 0, e, d);
      chk(e == 1'b1 && d == 8'h00, "R6 enable bad pipe", {e, d}, {1'b1, 8'h00});
      cmpSpi("R6");
    end else begin
      pushRmw(en ? (radioEn | (8'd1 << p)) : (radioEn & ~(8'd1 << p)));
      doOp(en ? 3'd2 : 3'd3, p, 8'h00, 1, e, d);
      chk(e == 1'b0 && d == 8'(p), "R4 enable/disable", {e, d}, p);
      cmpSpi("R4");
      expEn[p] = en;
    end
  endtask

  task automatic tFwd(input int p);
    logic e;
    logic [7:0] d;
    int xe = (p > 5) ? 1 : 0;
    int xd = (p > 5) ? 0 : expNode[p];
    doOp(3'd4, p, 8'h00, 0, e, d);
    chk(e == 1'(xe) && d == 8'(xd), "R7 forward lookup", {e, d}, {1'(xe), 8'(xd)});
    cmpSpi("R7");
  endtask

  task automatic tRev(input logic [7:0] n);
    logic e;
    logic [7:0] d;
    int p = -1;
    for (int i = 5; i >= 0; i--) if (expNode[i] == int'(n)) p = i;
    doOp(3'd5, 0, n, 0, e, d);
    if (p < 0) chk(e == 1'b1 && d == 8'hFF, "R8 reverse miss", {e, d}, {1'b1, 8'hFF});
    else chk(e == 1'b0 && d == 8'(p), "R8 reverse hit", {e, d}, p);
    cmpSpi("R8");
  endtask

  task automatic tClear();
    logic e;
    logic [7:0] d;
    pushTx(8'h22, 0);
    pushTx(8'h00, 1);
    doOp(3'd6, 0, 8'h00, 1, e, d);
    chk(e == 1'b0 && d == 8'h00, "R9 clear response", {e, d}, 0);
    cmpSpi("R9");
    for (int i = 0; i < 6; i++) begin
      expNode[i] = 0;
      expEn[i] = 0;
    end
  endtask

  initial begin
    logic [7:0] d;
    int lat;
    for (int i = 0; i < 6; i++) begin
      expNode[i] = 0;
      expEn[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk(!busy && !respValid && !spiValid, "R1 outputs in reset", {busy, respValid, spiValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !respValid && !spiValid, "R1 outputs after reset", {busy, respValid, spiValid}, 0);
    tFwd(3);

    tAdd(8'h11);
    chk(radioEn == 8'hC1, "R4 outside bits kept", radioEn, 8'hC1);
    tAdd(8'h22);
    tAdd(8'h33);
    tAdd(8'h44);
    tAdd(8'h55);
    tAdd(8'h66);
    tAdd(8'h77);

    tFwd(2);
    tFwd(6);
    tRev(8'h55);
    tRev(8'h99);

    tSetAddr(7, 8'h12);
    tSetAddr(3, 8'h55);
    tRev(8'h55);
    tFwd(3);

    tEnDis(1, 0);
    chk(radioEn == 8'hFD, "R4 disable clears bit", radioEn, 8'hFD);
    tAdd(8'h78);
    tEnDis(6, 1);

    // R10: a request held while busy is ignored
    tEnDis(4, 0);
    pushRmw(radioEn & ~8'h20);
    @(negedge clk);
    quiet = 0;
    logB.delete();
    logL.delete();
    reqValid = 1'b1;
    reqOp = 3'd3;
    reqPipe = 3'd5;
    @(negedge clk);
    reqOp = 3'd6;
    lat = 0;
    while (!respValid && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    reqValid = 1'b0;
    d = respData;
    chk(d == 8'd5, "R10 first request served", d, 5);
    cmpSpi("R10");
    @(negedge clk);
    chk(!respValid && !busy, "R10 held request ignored", {respValid, busy}, 0);
    quiet = 1;
    expEn[5] = 0;
    tFwd(0);

    tClear();
    chk(radioEn == 8'h00, "R9 enable register zero", radioEn, 0);
    tFwd(0);
    tRev(8'h00);
    tAdd(8'h12);
    tAdd(8'h13);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule